// File: doc/BRIEF.md
# Configuration Register Bank with Per-Bit Access Policies

This block holds a small set of 32-bit configuration registers. A single-master bus reaches them. The bus carries a request strobe, a write flag, a word address, write data and four byte enables. Every request is acknowledged on the following clock edge, and a read returns its data in that same cycle. Each bit has a fixed access policy: read-only, read/write, write-one-to-clear status, write-once, or lockable. The lockable bits sit under a lock bit in the same register, and only a reset clears that lock bit.

The register layout is fixed:
- Word 0 is an identity word. It is read-only and carries a revision field and a copy of the strap pins.
- Word 1 is a control word. It has a free read/write field, a lockable field and the lock bit.
- Word 2 is a status word. Hardware event inputs set its bits and software clears them.
- Word 3 is a write-once setup word. Its low byte defaults to the strap pins.
- All other addresses are reserved. They complete normally and read as zero.

Top module: `cfg_reg_bank`

## Requirements
- R1: Every request (`req_i` high at a rising edge), reserved addresses included, raises `ack_o` for exactly the next cycle. When there is no request, `ack_o` is low. For a read, `rdata_o` in the acknowledge cycle holds the register value before the edge. For a write, `rdata_o` is zero.
- R2: A word address of 4 or higher is reserved. Reading it returns zero, and writing it changes no register.
- R3: Word 0 is read-only and writes leave it unchanged. Bits [31:16] are 16'hC5A1, bits [15:8] are the `REV_ID` parameter (default 8'h03), and bits [7:0] are the strap value.
- R4: Word 1 bits [15:0] are read/write and reset to 16'h0010. Byte lane k (`be_i[k]`) alone decides whether bits [8k+7:8k] take the write data.
- R5: Reserved bit positions always read zero and ignore written ones. These are word 1 [30:24], word 2 [31:8] and word 3 [31:16].
- R6: Word 2 bits [7:0] are status bits. A high `evt_i[k]` sets bit k on the next edge. A write of 1 with byte lane 0 enabled clears the bit, and a write of 0 leaves it. When a set and a clear meet in the same cycle, the bit ends up set.
- R7: Word 3 bits [15:0] are write-once per byte lane. The first write that enables a lane loads that lane, and the lane is frozen from then until reset. A write that disables the lane does not use up its permission.
- R8: Word 1 bit 31 is the lock bit, and writing a 1 sets it. Writing a 0 never clears it, and only reset does. While it is set, word 1 bits [23:16] (reset 8'h00) ignore writes, and bits [15:0] stay writable.
- R9: Reset loads every register default. The strap value at reset supplies word 0 [7:0] and word 3 [7:0], and word 3 [15:8] resets to 8'h3C. Reset also reopens every write-once lane.
- R10: A write with all byte enables low changes no bit under any policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; straps load while low |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for writes |
| evt_i | input | 8 | Hardware set events for status bits |
| strap_i | input | 8 | Strap value loaded at reset |
| ack_o | output | 1 | Access complete, one cycle after request |
| rdata_o | output | 32 | Read data, valid with ack_o |

## Verification
On every cycle the assertions check the following:
- the acknowledge timing
- zero read data from reserved addresses
- the zero content of reserved bit positions
- the stickiness of the lock bit
- the frozen lockable field once the lock is set
- the frozen write-once lane after its first enabled write
- that every event is captured in the status register

Some behaviours need chosen access sequences, and only the bench scenarios show them:
- the exact register values after masked writes
- a status clear racing an event in the same cycle
- the strap-derived defaults
- the reopening of write-once lanes and of the lock after a second reset

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BYTES    = DATA_W / 8;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned EVT_W    = 8;
  localparam int unsigned STRAP_W  = 8;

  // one mask per policy; bits in no mask are reserved and read zero
  typedef struct packed {
    logic [DATA_W-1:0] ro;
    logic [DATA_W-1:0] rw;
    logic [DATA_W-1:0] w1c;
    logic [DATA_W-1:0] wo;
    logic [DATA_W-1:0] lk;
    logic [DATA_W-1:0] ls;
    logic [DATA_W-1:0] strap;
    logic [DATA_W-1:0] rstv;
  } reg_attr_t;

  function automatic reg_attr_t attr_of(int idx, logic [7:0] rev);
    reg_attr_t a;
    a = '0;
    case (idx)
      0: begin
        a.ro    = 32'hFFFF_FFFF;
        a.strap = 32'h0000_00FF;
        a.rstv  = {16'hC5A1, rev, 8'h00};
      end
      1: begin
        a.rw   = 32'h0000_FFFF;
        a.lk   = 32'h00FF_0000;
        a.ls   = 32'h8000_0000;
        a.rstv = 32'h0000_0010;
      end
      2: begin
        a.w1c  = 32'h0000_00FF;
      end
      3: begin
        a.wo    = 32'h0000_FFFF;
        a.strap = 32'h0000_00FF;
        a.rstv  = 32'h0000_3C00;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [BYTES-1:0] lanes_of(logic [DATA_W-1:0] m);
    logic [BYTES-1:0] l;
    for (int b = 0; b < BYTES; b++) l[b] = |m[8*b +: 8];
    return l;
  endfunction
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NUM    = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM-1:0]    sel_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/cfg_reg_cell.sv
module cfg_reg_cell
  import cfg_bank_pkg::*;
#(
  parameter reg_attr_t ATTR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] strap_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [DATA_W-1:0] IMPL =
    ATTR.ro | ATTR.rw | ATTR.w1c | ATTR.wo | ATTR.lk | ATTR.ls;
  localparam logic [BYTES-1:0] WO_LANE = lanes_of(ATTR.wo);

  logic [DATA_W-1:0] q, d, wmask, be_bits, wo_open;
  logic [BYTES-1:0]  wo_done_q;
  logic              locked;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign be_bits[8*b +: 8] = {8{be_i[b]}};
    assign wo_open[8*b +: 8] = {8{~wo_done_q[b]}};
  end

  assign locked = |(q & ATTR.ls);
  assign wmask  = {DATA_W{wr_i}} & be_bits;

  always_comb begin
    logic [DATA_W-1:0] m;
    d = q;
    m = ATTR.rw & wmask;
    d = (d & ~m) | (wdata_i & m);
    m = ATTR.lk & wmask & {DATA_W{~locked}};
    d = (d & ~m) | (wdata_i & m);
    m = ATTR.wo & wmask & wo_open;
    d = (d & ~m) | (wdata_i & m);
    d = d & ~(ATTR.w1c & wmask & wdata_i);
    d = d | (ATTR.w1c & set_i);          // set beats clear
    d = d | (ATTR.ls & wmask & wdata_i); // lock is set-only
    d = d & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q         <= ((ATTR.rstv & ~ATTR.strap) | (strap_i & ATTR.strap)) & IMPL;
      wo_done_q <= '0;
    end else begin
      q         <= d;
      wo_done_q <= wo_done_q | ({BYTES{wr_i}} & be_i & WO_LANE);
    end
  end

  assign q_o = q;
endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port
  import cfg_bank_pkg::*;
#(
  parameter int unsigned NUM = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [NUM-1:0]    sel_i,
  input  logic [DATA_W-1:0] reg_i [NUM],
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    for (int i = 0; i < NUM; i++) if (sel_i[i]) mux = mux | reg_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= req_i;
      rdata_o <= (req_i && !we_i) ? mux : '0;
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [7:0]  REV_ID = 8'h03
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [BYTES-1:0]   be_i,
  input  logic [EVT_W-1:0]   evt_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               ack_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [NUM_REGS-1:0] sel;
  logic [DATA_W-1:0]   reg_q [NUM_REGS];
  logic [DATA_W-1:0]   strap_w, evt_w;

  assign strap_w = DATA_W'(strap_i);
  assign evt_w   = DATA_W'(evt_i);

  cfg_addr_dec #(.ADDR_W(ADDR_W), .NUM(NUM_REGS)) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam reg_attr_t A = attr_of(i, REV_ID);
    cfg_reg_cell #(.ATTR(A)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (req_i & we_i & sel[i]),
      .be_i   (be_i),
      .wdata_i(wdata_i),
      .set_i  ((A.w1c != '0) ? evt_w : '0),
      .strap_i(strap_w),
      .q_o    (reg_q[i])
    );
  end

  cfg_rd_port #(.NUM(NUM_REGS)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .sel_i  (sel),
    .reg_i  (reg_q),
    .ack_o  (ack_o),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/cfg_reg_bank_chk.sv
module cfg_reg_bank_chk
  import cfg_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTES-1:0]  be_i,
  input logic [EVT_W-1:0]  evt_i,
  input logic              ack_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] reg_q [NUM_REGS]
);
  logic wo0_done;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wo0_done <= 1'b0;
    else if (req_i && we_i && addr_i == ADDR_W'(3) && be_i[0]) wo0_done <= 1'b1;
  end

  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o); // R1
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o); // R1
  AST_RSVD_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i >= ADDR_W'(NUM_REGS)) |=> rdata_o == '0); // R2
  AST_RSVD_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_q[1][30:24] == '0 && reg_q[2][31:8] == '0 && reg_q[3][31:16] == '0); // R5
  AST_EVT_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> (reg_q[2][7:0] & $past(evt_i)) == $past(evt_i)); // R6
  AST_WO_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wo0_done |=> $stable(reg_q[3][7:0])); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_q[1][31] |=> reg_q[1][31]); // R8
  AST_LOCKED_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_q[1][31] |=> $stable(reg_q[1][23:16])); // R8
  AST_RO_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> $stable(reg_q[0])); // R3
endmodule

bind cfg_reg_bank cfg_reg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .be_i   (be_i),
  .evt_i  (evt_i),
  .ack_o  (ack_o),
  .rdata_o(rdata_o),
  .reg_q  (reg_q)
);

// File: tb/sim_cfg_reg_bank.sv
`timescale 1ns/1ps
module sim_cfg_reg_bank;
  localparam time CYC = 20ns;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0, be = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  evt = '0, strap = 8'h96;
  logic        ack;
  logic [31:0] rdata;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CYC/2) clk = ~clk;

  cfg_reg_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .evt_i(evt), .strap_i(strap),
    .ack_o(ack), .rdata_o(rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  adr;
    logic [31:0] dat;
    logic [3:0]  ben;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  // each vector: optional write, then read of the same word compared to exp
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0, 32'h0,         4'h0, 32'hC5A1_0396, 4'd9},  // R9 R3 reset + strap
    '{1'b1, 4'd0, 32'hFFFF_FFFF, 4'hF, 32'hC5A1_0396, 4'd3},  // R3 read-only
    '{1'b0, 4'd1, 32'h0,         4'h0, 32'h0000_0010, 4'd9},  // R9
    '{1'b1, 4'd1, 32'hFFFF_FFFF, 4'h3, 32'h0000_FFFF, 4'd4},  // R4 lanes 0,1
    '{1'b1, 4'd1, 32'h7FAB_1234, 4'hF, 32'h00AB_1234, 4'd5},  // R5 R4
    '{1'b1, 4'd1, 32'hFFFF_FFFF, 4'h0, 32'h00AB_1234, 4'd10}, // R10
    '{1'b0, 4'd3, 32'h0,         4'h0, 32'h0000_3C96, 4'd9},  // R9
    '{1'b1, 4'd3, 32'h0000_5500, 4'h2, 32'h0000_5596, 4'd7},  // R7 lane 1 only
    '{1'b1, 4'd3, 32'hFFFF_AAAA, 4'hF, 32'h0000_55AA, 4'd7},  // R7 lane 0 first
    '{1'b1, 4'd3, 32'h0000_1111, 4'h3, 32'h0000_55AA, 4'd7},  // R7 frozen
    '{1'b1, 4'd7, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, 4'd2},  // R2 reserved
    '{1'b1, 4'd1, 32'h8000_0000, 4'h8, 32'h80AB_1234, 4'd8},  // R8 set lock
    '{1'b1, 4'd1, 32'h0012_5678, 4'hF, 32'h80AB_5678, 4'd8}   // R8 locked
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [3:0] a, input logic [31:0] d,
                        input logic [3:0] b, input logic [7:0] e, output logic [31:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = b; evt = e;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0; evt = '0;
    r = rdata;
    check({31'b0, ack}, 32'd1, "R1 ack");
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b,
                    input logic [7:0] e);
    logic [31:0] r;
    access(1'b1, a, d, b, e, r);
    check(r, 32'h0, "R1 write rdata");
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] r;
    access(1'b0, a, 32'h0, 4'h0, 8'h0, r);
    check(r, exp, tag);
  endtask

  initial begin
    #(CYC * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({31'b0, ack}, 32'd0, "R1 ack idle in reset");
    check(rdata, 32'h0, "R9 rdata reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check({31'b0, ack}, 32'd0, "R1 no ack without request");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].adr, VECS[i].dat, VECS[i].ben, 8'h00);
      rd_chk(VECS[i].adr, VECS[i].exp, $sformatf("R%0d vec %0d", VECS[i].rq, i));
    end

    // R2 reserved words left registers untouched
    rd_chk(4'd15, 32'h0, "R2 top address");
    rd_chk(4'd2, 32'h0, "R2 status untouched");

    // R6 status: set by events, clear by write-one, set wins
    wr(4'd0, 32'h0, 4'h0, 8'h0F);
    rd_chk(4'd2, 32'h0000_000F, "R6 event set");
    wr(4'd2, 32'hFFFF_FF05, 4'h1, 8'h00);
    rd_chk(4'd2, 32'h0000_000A, "R6 clear ones, keep zeros, R5");
    wr(4'd2, 32'hFFFF_FFFF, 4'h0, 8'h00);
    rd_chk(4'd2, 32'h0000_000A, "R10 R6 lane disabled");
    wr(4'd2, 32'h0000_0002, 4'h1, 8'h02);
    rd_chk(4'd2, 32'h0000_000A, "R6 set beats clear");
    wr(4'd2, 32'h0000_00FF, 4'h1, 8'h00);
    rd_chk(4'd2, 32'h0000_0000, "R6 clear all");

    // R9 second reset with new straps, lock and write-once reopen
    @(negedge clk);
    strap = 8'h41;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    rd_chk(4'd0, 32'hC5A1_0341, "R9 R3 new strap");
    rd_chk(4'd1, 32'h0000_0010, "R9 R8 lock cleared");
    rd_chk(4'd3, 32'h0000_3C41, "R9 write-once default");
    wr(4'd3, 32'h0000_0077, 4'h1, 8'h00);
    rd_chk(4'd3, 32'h0000_3C77, "R7 R9 lane reopened");
    wr(4'd1, 32'h0055_0000, 4'h4, 8'h00);
    rd_chk(4'd1, 32'h0055_0010, "R8 unlocked field writable");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule